// File: doc/BRIEF.md
# On-Screen Display Character Memory and Enable Controller

This block sits between a processor's paged data window and the display engine of a character-based on-screen display. It holds the character memory (five rows of sixteen bytes, the first byte of each row being a hidden format byte and the remaining fifteen the visible character codes) and five control bytes. It also holds a one-bit enable register. The processor reaches all of these through two page values of an externally held page register, using a six-bit offset. The processor can only write. No processor read path exists.

The enable register decides when the display runs. Setting it arms the controller, and the display becomes active only on the next rising edge of the synchronised vertical sync input. Clearing it stops the display at the same clock edge. While the enable bit is set, every other location is locked. A write to a locked location is dropped and sets a sticky error flag. The display engine reads the character memory through its own read-only port, addressed by row and column, with one clock of latency.

Top module: `osd_frontend`

## Requirements
- R1: While reset is asserted and at the first edge after it, all outputs are zero: rd_data, ctrl_bytes, enable_bit, disp_active and wr_err.
- R2: With cpu_page = 0x20, a write at any offset 0x00 to 0x3F stores the byte at row = offset[5:4], column = offset[3:0].
- R3: With cpu_page = 0x40, a write at offsets 0x00 to 0x0F stores the byte in row 4, column = offset[3:0].
- R4: With cpu_page = 0x40, a write at offsets 0x10 to 0x14 stores the byte in control byte (offset − 0x10), which appears on ctrl_bytes[8*i +: 8] from the next edge.
- R5: Writes with any other page value, or with cpu_page = 0x40 at offsets 0x15, 0x16 or 0x18 to 0x3F, change no memory or register and do not set wr_err.
- R6: The enable register at cpu_page = 0x40, offset 0x17, takes cpu_wdata[0] on any write, whatever the display state. enable_bit shows the new value from the next edge.
- R7: While enable_bit is 1, writes to memory or control bytes are dropped, and wr_err becomes 1 at the next edge. wr_err stays 1 until reset.
- R8: Once enabled, disp_active rises only after a rising edge of vsync. If vsync is sampled 0 at edge k−1 and 1 at edges k and k+1, disp_active is 1 after edge k+2.
- R9: A vsync rising edge while the enable bit is clear has no effect. After enabling, a vsync that is already high does not start the display, and only a later rising edge does.
- R10: A write of 0 to the enable register makes disp_active 0 at the same edge at which enable_bit becomes 0.
- R11: rd_data shows the byte at (rd_row, rd_col) one edge after the address is presented. It is zero when rd_row is greater than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_page | input | 8 | Current page register value |
| cpu_ofs | input | 6 | Offset within the page |
| cpu_wdata | input | 8 | Write data |
| vsync | input | 1 | Asynchronous vertical sync |
| rd_row | input | 3 | Display read row |
| rd_col | input | 4 | Display read column |
| rd_data | output | 8 | Display read data, registered |
| ctrl_bytes | output | 40 | The five control bytes, byte i at bits 8*i+7..8*i |
| enable_bit | output | 1 | Enable register value |
| disp_active | output | 1 | Display running |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the block with its default parameters: five rows of sixteen columns, a six-bit offset, five control bytes and a two-stage sync. With these values the bench can write every boundary offset of both pages and the unmapped holes around the enable register. It can also read the out-of-range rows 5 and 7. Because of the short sync chain, the three-edge start latency, a vsync held high across enabling, and enable-then-disable before any edge can all be observed exactly.

// File: rtl/osd_fe_pkg.sv
package osd_fe_pkg;
  typedef enum logic [1:0] {
    RUN_OFF   = 2'd0,
    RUN_ARMED = 2'd1,
    RUN_ON    = 2'd2
  } run_state_t;

  function automatic int flat_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction

  function automatic bit in_window(input int v, input int base, input int n);
    return (v >= base) && (v < base + n);
  endfunction
endpackage

// File: rtl/osd_fe_decode.sv
module osd_fe_decode #(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 6,
  parameter int ROWS       = 5,
  parameter int COLS       = 16,
  parameter int CTRL_N     = 5,
  parameter int CTRL_BASE  = 16,
  parameter int ENABLE_OFS = 23,
  parameter int PAGE_LO    = 32,
  parameter int PAGE_HI    = 64,
  parameter int IDX_W      = 7,
  parameter int CI_W       = 3
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [OFS_W-1:0]  ofs,
  output logic              hit_ram,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              hit_ctrl,
  output logic [CI_W-1:0]   ctrl_idx,
  output logic              hit_en
);
  import osd_fe_pkg::*;

  localparam int LO_ROWS  = (1 << OFS_W) / COLS;
  localparam int LO_BYTES = LO_ROWS * COLS;
  localparam int HI_BYTES = (ROWS - LO_ROWS) * COLS;

  int ofs_i;
  int page_i;

  always_comb begin
    ofs_i    = int'(ofs);
    page_i   = int'(page);
    hit_ram  = 1'b0;
    ram_idx  = '0;
    hit_ctrl = 1'b0;
    ctrl_idx = '0;
    hit_en   = 1'b0;
    if (page_i == PAGE_LO) begin
      hit_ram = in_window(ofs_i, 0, LO_BYTES);
      ram_idx = IDX_W'(ofs_i);
    end else if (page_i == PAGE_HI) begin
      if (in_window(ofs_i, 0, HI_BYTES)) begin
        hit_ram = 1'b1;
        ram_idx = IDX_W'(LO_BYTES + ofs_i);
      end else if (in_window(ofs_i, CTRL_BASE, CTRL_N)) begin
        hit_ctrl = 1'b1;
        ctrl_idx = CI_W'(ofs_i - CTRL_BASE);
      end else if (ofs_i == ENABLE_OFS) begin
        hit_en = 1'b1;
      end
    end
  end
endmodule

// File: rtl/osd_fe_charram.sv
module osd_fe_charram #(
  parameter int ROWS  = 5,
  parameter int COLS  = 16,
  parameter int DW    = 8,
  parameter int IDX_W = 7,
  parameter int ROW_W = 3,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [ROW_W-1:0] rd_row,
  input  logic [COL_W-1:0] rd_col,
  output logic [DW-1:0]    rd_data
);
  import osd_fe_pkg::*;

  localparam int DEPTH = ROWS * COLS;

  logic [DW-1:0]    mem [DEPTH];
  logic             rd_ok;
  logic [IDX_W-1:0] ridx;

  assign rd_ok = int'(rd_row) < ROWS;
  assign ridx  = IDX_W'(flat_index(int'(rd_row), int'(rd_col), COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (we) mem[widx] <= wdata;
      rd_data <= rd_ok ? mem[ridx] : '0;
    end
  end
endmodule

// File: rtl/osd_fe_runctl.sv
module osd_fe_runctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_we,
  input  logic                    en_val,
  input  logic                    vsync,
  output logic                    en_q,
  output logic                    vs_rise,
  output osd_fe_pkg::run_state_t  state
);
  import osd_fe_pkg::*;

  logic [SYNC_STAGES:0] vs_q;

  assign vs_rise = vs_q[SYNC_STAGES-1] & ~vs_q[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q  <= '0;
      en_q  <= 1'b0;
      state <= RUN_OFF;
    end else begin
      vs_q <= {vs_q[SYNC_STAGES-1:0], vsync};
      if (en_we) en_q <= en_val;
      if (en_we && !en_val) begin
        state <= RUN_OFF;
      end else begin
        case (state)
          RUN_OFF:   if (en_we && en_val) state <= RUN_ARMED;
          RUN_ARMED: if (vs_rise) state <= RUN_ON;
          default:   state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/osd_frontend.sv
module osd_frontend #(
  parameter int PAGE_W      = 8,
  parameter int OFS_W       = 6,
  parameter int DW          = 8,
  parameter int ROWS        = 5,
  parameter int COLS        = 16,
  parameter int CTRL_N      = 5,
  parameter int CTRL_BASE   = 16,
  parameter int ENABLE_OFS  = 23,
  parameter int PAGE_LO     = 32,
  parameter int PAGE_HI     = 64,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int COL_W      = $clog2(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [PAGE_W-1:0]    cpu_page,
  input  logic [OFS_W-1:0]     cpu_ofs,
  input  logic [DW-1:0]        cpu_wdata,
  input  logic                 vsync,
  input  logic [ROW_W-1:0]     rd_row,
  input  logic [COL_W-1:0]     rd_col,
  output logic [DW-1:0]        rd_data,
  output logic [CTRL_N*DW-1:0] ctrl_bytes,
  output logic                 enable_bit,
  output logic                 disp_active,
  output logic                 wr_err
);
  import osd_fe_pkg::*;

  localparam int IDX_W = $clog2(ROWS * COLS);
  localparam int CI_W  = (CTRL_N > 1) ? $clog2(CTRL_N) : 1;

  logic             hit_ram, hit_ctrl, hit_en;
  logic [IDX_W-1:0] ram_idx;
  logic [CI_W-1:0]  ctrl_idx;
  logic             ram_we, ctrl_we, en_we;
  logic             wr_locked, en_clear_wr, vs_rise;
  run_state_t       run_state;

  osd_fe_decode #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .ROWS(ROWS), .COLS(COLS),
    .CTRL_N(CTRL_N), .CTRL_BASE(CTRL_BASE), .ENABLE_OFS(ENABLE_OFS),
    .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI), .IDX_W(IDX_W), .CI_W(CI_W)
  ) u_dec (
    .page(cpu_page), .ofs(cpu_ofs),
    .hit_ram(hit_ram), .ram_idx(ram_idx),
    .hit_ctrl(hit_ctrl), .ctrl_idx(ctrl_idx), .hit_en(hit_en)
  );

  // Locked whenever the enable bit is set (armed or running).
  assign wr_locked   = cpu_wr & (hit_ram | hit_ctrl) & enable_bit;
  assign ram_we      = cpu_wr & hit_ram  & ~enable_bit;
  assign ctrl_we     = cpu_wr & hit_ctrl & ~enable_bit;
  assign en_we       = cpu_wr & hit_en;
  assign en_clear_wr = en_we & ~cpu_wdata[0];

  osd_fe_charram #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .IDX_W(IDX_W),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .widx(ram_idx), .wdata(cpu_wdata),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  osd_fe_runctl #(.SYNC_STAGES(SYNC_STAGES)) u_run (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_val(cpu_wdata[0]),
    .vsync(vsync), .en_q(enable_bit), .vs_rise(vs_rise), .state(run_state)
  );

  assign disp_active = (run_state == RUN_ON);

  for (genvar g = 0; g < CTRL_N; g++) begin : g_ctrl
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (ctrl_we && (ctrl_idx == CI_W'(g))) q <= cpu_wdata;
    end
    assign ctrl_bytes[g*DW +: DW] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         wr_err <= 1'b0;
    else if (wr_locked) wr_err <= 1'b1;
  end
endmodule

// File: rtl/osd_frontend_chk.sv
module osd_frontend_chk #(
  parameter int ROWS  = 5,
  parameter int ROW_W = 3,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_active,
  input logic             enable_bit,
  input logic             wr_err,
  input logic             wr_locked,
  input logic             en_clear_wr,
  input logic             vs_rise,
  input logic [ROW_W-1:0] rd_row,
  input logic [DW-1:0]    rd_data
);
  // R7
  locked_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_locked |=> wr_err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
  // R10
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clear_wr |=> !disp_active);
  // R8
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_active) |-> $past(vs_rise));
  // R8
  active_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_active |-> enable_bit);
  // R11
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_row) >= ROWS) |=> (rd_data == '0));
endmodule

bind osd_frontend osd_frontend_chk #(.ROWS(ROWS), .ROW_W(ROW_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_active(disp_active), .enable_bit(enable_bit),
  .wr_err(wr_err), .wr_locked(wr_locked), .en_clear_wr(en_clear_wr),
  .vs_rise(vs_rise), .rd_row(rd_row), .rd_data(rd_data)
);

// File: tb/osd_frontend_bench.sv
module osd_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_page = '0;
  logic [5:0]  cpu_ofs = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        vsync = 1'b0;
  logic [2:0]  rd_row = '0;
  logic [3:0]  rd_col = '0;
  logic [7:0]  rd_data;
  logic [39:0] ctrl_bytes;
  logic        enable_bit, disp_active, wr_err;

  always #2.5 clk = ~clk;

  osd_frontend u_osd_frontend (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_page(cpu_page),
    .cpu_ofs(cpu_ofs), .cpu_wdata(cpu_wdata), .vsync(vsync),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .ctrl_bytes(ctrl_bytes), .enable_bit(enable_bit),
    .disp_active(disp_active), .wr_err(wr_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_mem [80];
  int m_ctrl [5];
  int m_en, m_err, m_run;   // m_run: 0 off, 1 waiting for sync edge, 2 on
  int m_rd;
  bit vq[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 80; i++) m_mem[i] = 0;
    for (int i = 0; i < 5; i++) m_ctrl[i] = 0;
    m_en = 0; m_err = 0; m_run = 0; m_rd = 0;
    vq = '{0, 0, 0};
  endtask

  task automatic compare_all();
    longint cexp = 0;
    for (int i = 0; i < 5; i++) cexp |= longint'(m_ctrl[i]) << (8 * i);
    chk(cur_req, "rd_data", longint'(rd_data), longint'(m_rd));
    chk("R4", "ctrl_bytes", longint'(ctrl_bytes), cexp);
    chk("R6", "enable_bit", longint'(enable_bit), longint'(m_en));
    chk("R7", "wr_err", longint'(wr_err), longint'(m_err));
    chk("R8", "disp_active", longint'(disp_active), longint'(m_run == 2));
  endtask

  task automatic cyc(input bit we, input int pg, input int of, input int d,
                     input bit vs, input int r, input int c);
    bit rise;
    bit enw;
    @(negedge clk);
    cpu_wr = we; cpu_page = 8'(pg); cpu_ofs = 6'(of); cpu_wdata = 8'(d);
    vsync = vs; rd_row = 3'(r); rd_col = 4'(c);
    @(posedge clk);
    rise = vq[1] && !vq[0];
    vq.push_back(vs);
    void'(vq.pop_front());
    m_rd = (r < 5) ? m_mem[r * 16 + c] : 0;
    enw = 0;
    if (we) begin
      if (pg == 32) begin
        if (m_en != 0) m_err = 1; else m_mem[of] = d;
      end else if (pg == 64) begin
        if (of < 16) begin
          if (m_en != 0) m_err = 1; else m_mem[64 + of] = d;
        end else if (of >= 16 && of <= 20) begin
          if (m_en != 0) m_err = 1; else m_ctrl[of - 16] = d;
        end else if (of == 23) enw = 1;
      end
    end
    if (enw && d[0] == 1'b0) begin
      m_en = 0; m_run = 0;
    end else begin
      if (enw) m_en = 1;
      if (m_run == 0 && enw) m_run = 1;
      else if (m_run == 1 && rise) m_run = 2;
    end
    #1 compare_all();
  endtask

  task automatic wr(input int pg, input int of, input int d);
    cyc(1, pg, of, d, vsync, 0, 0);
  endtask

  task automatic rd(input int r, input int c);
    cyc(0, 0, 0, 0, vsync, r, c);
  endtask

  task automatic idle(input int n, input bit vs);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, vs, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "rd_data", longint'(rd_data), 0);
    chk("R1", "ctrl_bytes", longint'(ctrl_bytes), 0);
    chk("R1", "enable_bit", longint'(enable_bit), 0);
    chk("R1", "disp_active", longint'(disp_active), 0);
    chk("R1", "wr_err", longint'(wr_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(1, 0);

    // R2 low page, boundaries and middle
    cur_req = "R2";
    wr(32, 0, 8'hA0); wr(32, 15, 8'hA1); wr(32, 16, 8'hA2);
    wr(32, 63, 8'hA3); wr(32, 37, 8'hA4);
    rd(0, 0); rd(0, 15); rd(1, 0); rd(3, 15); rd(2, 5); rd(2, 6);

    // R3 high page row 4
    cur_req = "R3";
    wr(64, 0, 8'hB0); wr(64, 15, 8'hB1); wr(64, 7, 8'hB2);
    rd(4, 0); rd(4, 15); rd(4, 7); rd(4, 8);

    // R4 control bytes
    cur_req = "R4";
    for (int i = 0; i < 5; i++) wr(64, 16 + i, 8'h10 * (i + 1) + i);
    idle(1, 0);

    // R5 ignored writes
    cur_req = "R5";
    wr(0, 0, 8'hEE); wr(96, 0, 8'hEE); wr(33, 0, 8'hEE); wr(65, 0, 8'hEE);
    wr(64, 21, 8'hEE); wr(64, 22, 8'hEE); wr(64, 24, 8'hEE); wr(64, 63, 8'hEE);
    rd(0, 0); rd(4, 0); rd(0, 1);

    // R11 out-of-range rows
    cur_req = "R11";
    rd(5, 0); rd(7, 15); rd(1, 0); rd(6, 3);

    // R9 sync edge while disabled, then enable with vsync already high
    cur_req = "R9";
    idle(4, 1); idle(2, 0); idle(2, 1);
    wr(64, 23, 1);
    idle(6, 1);

    // R8 later rising edge starts the display
    cur_req = "R8";
    idle(2, 0); idle(5, 1); idle(3, 0);

    // R7 locked writes while running
    cur_req = "R7";
    wr(32, 5, 8'h55); wr(64, 3, 8'h55); wr(64, 18, 8'h55);
    rd(0, 5); rd(4, 3);

    // R10 immediate stop, then writes accepted again, error stays
    cur_req = "R10";
    wr(64, 23, 0);
    idle(2, 0);
    wr(32, 5, 8'h66); rd(0, 5); rd(0, 5);

    // R6 enable written while armed, locked in armed state, disable before edge
    cur_req = "R6";
    wr(64, 23, 1); wr(64, 23, 1);
    wr(64, 17, 8'h77);
    wr(64, 23, 0);
    idle(2, 1); idle(3, 0);
    wr(64, 17, 8'h78); idle(1, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule